// File: doc/BRIEF.md
# Flash Command Interface Controller

This block sits between a processor-style bus and a model of a block-organised flash array. Every change to the array is started by a two-cycle command sequence: a setup write, then a confirm or data write. A single engine times each erase, program or lock-bit operation with a down-counter. The engine can be suspended and resumed, and the two kinds of suspend follow different rules. A suspended erase lets the host read, and also program blocks other than the one being erased. A suspended program lets the host only read.

Writes are protected in three independent ways, plus the per-block lock bits. While the core supply is not valid, or the hold-reset pin is low, the command interface ignores every write. While the programming supply is not valid, no erase, program or lock change can alter the array. Reads return either array data or an 8-bit status byte. Which one depends on the read mode that the last command left behind. In byte mode, the lowest address bit selects a byte lane. In word mode, that bit is unused, so block boundaries sit at the same byte addresses in both modes.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: An erase starts only after setup code 8'h2E and then confirm 8'hC3. A program starts only after setup 8'h4C and then a data write. A lock change starts only after setup 8'h6B and then 8'h15 (set the lock) or 8'hC3 (clear the lock). A setup write by itself alters no array word and sets no busy state.
- R2: If the second write after an erase or lock setup carries any other code, the sequence is dropped. Status bit 5 (sequence error) is set and the array is left unchanged.
- R3: When the programming supply is not valid at the confirm, the operation does not start. When it is not valid at the final cycle, nothing is committed. In both cases status bit 3 (voltage error) is set, and no array word and no lock bit changes.
- R4: While vcc_ok is low or hold_rst_n is low, every write is ignored. Holding hold_rst_n low also aborts any operation, returns reads to array mode and clears the error bits. The array and the lock bits are kept.
- R5: An erase or program aimed at a locked block is refused. Status bit 1 (lock violation) is set and the array is unchanged.
- R6: busy rises at the confirm edge and stays high for ERASE_CYC, PROG_CYC or LOCK_CYC cycles. The change commits on the edge where busy falls. An erase sets every word of the block to 16'hFFFF. A program ANDs the data into the addressed word.
- R7: The suspend code 8'hB5, given during a running erase or top-level program, is acknowledged exactly SUSP_LAT edges later. At that point busy drops and status bit 6 (erase suspended) or bit 2 (program suspended) is set.
- R8: During an erase suspend, Read Array works and programs to other blocks run and finish with bit 6 still set. A program aimed at the suspended block sets bit 5 instead.
- R9: During a program suspend, only reads are allowed. Any erase, program or lock setup sets bit 5 and starts nothing.
- R10: The resume code 8'hC3, given while suspended, continues the operation. It finishes after exactly the cycle count that was still remaining when it was suspended.
- R11: Any setup, suspend, resume or 8'h7A write switches reads to status. Status stays selected after completion until Read Array 8'hF0 is written. Read Array is ignored while busy.
- R12: The block index is addr[8:4] and the word index is addr[8:1]. In byte mode, addr[0]=1 selects the high byte lane for both reads and programs. A byte read returns the selected byte in dout[7:0] with zero above it.
- R13: dout is updated on the edge after rd_en. Status reads give {8'h00, status}: bit 7 ready, bit 6 erase suspended, bit 5 sequence error, bit 3 voltage error, bit 2 program suspended, bit 1 lock violation, and bits 4 and 0 zero. After rst_n, reads are in array mode and every word reads 16'hFFFF.
- R14: Writing 8'h5A clears bits 5, 3 and 1 of the status byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low; clears the array model and the locks |
| hold_rst_n | input | 1 | Reset pin, active low; aborts operations and disables writes |
| vcc_ok | input | 1 | Core supply above its write-lockout level |
| vpp_ok | input | 1 | Programming supply above its lockout level |
| byte_mode | input | 1 | 1 = byte-wide addressing, 0 = word-wide |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| rd_en | input | 1 | Bus read strobe, one cycle per read |
| addr | input | BLK_BITS+WORD_BITS+1 | Byte address |
| din | input | 16 | Write data; commands are taken from din[7:0] |
| dout | output | 16 | Read data or status |
| busy | output | 1 | An operation is running and is not suspended |

## Verification
A write sampled at edge k starts its operation there, so busy is sampled high one cycle before edge k+N and low just after it. The array contents are then checked by a read that lands one edge after rd_en. A suspend sampled at edge s is checked as not yet acknowledged after edge s+SUSP_LAT-1 and as acknowledged after edge s+SUSP_LAT. The bench computes the remaining count from the number of edges it waited, and times the resumed run against that count. All samples are taken at falling edges, after the register that produces each result has been updated, and the expected values come from a bench model of the array, the locks and the status bits.

// File: rtl/flash_cmd_ctrl.sv
`timescale 1ns/1ps
module flash_cmd_ctrl #(
  parameter int BLK_BITS  = 5,
  parameter int WORD_BITS = 3,
  parameter int ERASE_CYC = 40,
  parameter int PROG_CYC  = 12,
  parameter int LOCK_CYC  = 8,
  parameter int SUSP_LAT  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        hold_rst_n,
  input  logic                        vcc_ok,
  input  logic                        vpp_ok,
  input  logic                        byte_mode,
  input  logic                        wr_en,
  input  logic                        rd_en,
  input  logic [BLK_BITS+WORD_BITS:0] addr,
  input  logic [15:0]                 din,
  output logic [15:0]                 dout,
  output logic                        busy
);
  localparam int IDX_W  = BLK_BITS + WORD_BITS;
  localparam int NBLK   = 1 << BLK_BITS;
  localparam int NWORD  = 1 << IDX_W;
  localparam int WPB    = 1 << WORD_BITS;
  localparam int MAXC   = (ERASE_CYC > PROG_CYC) ? ((ERASE_CYC > LOCK_CYC) ? ERASE_CYC : LOCK_CYC)
                                                 : ((PROG_CYC > LOCK_CYC) ? PROG_CYC : LOCK_CYC);
  localparam int CNT_W  = $clog2(MAXC + 1);
  localparam int SW     = $clog2(SUSP_LAT + 1);

  localparam logic [7:0] C_RD_ARRAY = 8'hF0;
  localparam logic [7:0] C_RD_STAT  = 8'h7A;
  localparam logic [7:0] C_CLR_STAT = 8'h5A;
  localparam logic [7:0] C_ERASE    = 8'h2E;
  localparam logic [7:0] C_PROG     = 8'h4C;
  localparam logic [7:0] C_LOCK     = 8'h6B;
  localparam logic [7:0] C_GO       = 8'hC3;
  localparam logic [7:0] C_LOCK_SET = 8'h15;
  localparam logic [7:0] C_SUSP     = 8'hB5;

  typedef enum logic [1:0] {P_NONE, P_ERASE, P_PROG, P_LOCK} pend_t;
  typedef enum logic [1:0] {O_ERASE, O_PROG, O_LSET, O_LCLR} op_t;

  logic [15:0]         mem [NWORD];
  logic [NBLK-1:0]     lock_q;
  pend_t               pend;
  op_t                 op;
  logic                run, esus, psus, stat_mode;
  logic                seq_err, vpp_err, lock_err;
  logic [BLK_BITS-1:0] op_blk, e_blk;
  logic [IDX_W-1:0]    op_word;
  logic [15:0]         op_data;
  logic [CNT_W-1:0]    cnt, e_cnt;
  logic [SW-1:0]       spend;

  wire [IDX_W-1:0]    widx  = addr[IDX_W:1];
  wire [BLK_BITS-1:0] bidx  = addr[IDX_W -: BLK_BITS];
  wire [7:0]          cmd   = din[7:0];
  wire                wr_ok = wr_en && vcc_ok && hold_rst_n;
  wire [15:0]         wdata = !byte_mode ? din :
                              addr[0] ? {din[7:0], 8'hFF} : {8'hFF, din[7:0]};
  wire                active = run && !psus;
  wire                finish = active && (cnt == CNT_W'(1));
  wire                commit = finish && vpp_ok && hold_rst_n;
  wire                freeze = active && !finish && (spend == SW'(1));
  wire                locked = lock_q[bidx];
  wire                setup_ok = (cmd == C_PROG) ? !run : (!run && !esus);
  wire                susp_ok = active && !finish && (spend == '0) &&
                                (op == O_ERASE || (op == O_PROG && !esus));
  wire [7:0]          status = {!busy, esus, seq_err, 1'b0, vpp_err, psus, lock_err, 1'b0};

  assign busy = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= P_NONE; op <= O_ERASE; run <= 1'b0; esus <= 1'b0; psus <= 1'b0;
      stat_mode <= 1'b0; seq_err <= 1'b0; vpp_err <= 1'b0; lock_err <= 1'b0;
      op_blk <= '0; e_blk <= '0; op_word <= '0; op_data <= '0;
      cnt <= '0; e_cnt <= '0; spend <= '0;
    end else if (!hold_rst_n) begin
      pend <= P_NONE; run <= 1'b0; esus <= 1'b0; psus <= 1'b0; spend <= '0;
      stat_mode <= 1'b0; seq_err <= 1'b0; vpp_err <= 1'b0; lock_err <= 1'b0;
    end else begin
      if (finish) begin
        run   <= 1'b0;
        spend <= '0;
        if (!vpp_ok) vpp_err <= 1'b1;
      end else if (freeze) begin
        spend <= '0;
        if (op == O_ERASE) begin
          esus  <= 1'b1;
          e_blk <= op_blk;
          e_cnt <= cnt;
          run   <= 1'b0;
        end else begin
          psus <= 1'b1;
        end
      end else if (active) begin
        cnt <= cnt - 1'b1;
        if (spend != '0) spend <= spend - 1'b1;
      end

      if (wr_ok) begin
        if (pend != P_NONE) begin
          pend <= P_NONE;
          case (pend)
            P_ERASE: begin
              if (cmd != C_GO) seq_err <= 1'b1;
              else if (locked) lock_err <= 1'b1;
              else if (!vpp_ok) vpp_err <= 1'b1;
              else begin
                run <= 1'b1; op <= O_ERASE; op_blk <= bidx; cnt <= CNT_W'(ERASE_CYC);
              end
            end
            P_PROG: begin
              if (esus && bidx == e_blk) seq_err <= 1'b1;
              else if (locked) lock_err <= 1'b1;
              else if (!vpp_ok) vpp_err <= 1'b1;
              else begin
                run <= 1'b1; op <= O_PROG; op_blk <= bidx; op_word <= widx;
                op_data <= wdata; cnt <= CNT_W'(PROG_CYC);
              end
            end
            P_LOCK: begin
              if (cmd != C_LOCK_SET && cmd != C_GO) seq_err <= 1'b1;
              else if (!vpp_ok) vpp_err <= 1'b1;
              else begin
                run <= 1'b1; op_blk <= bidx; cnt <= CNT_W'(LOCK_CYC);
                op <= (cmd == C_LOCK_SET) ? O_LSET : O_LCLR;
              end
            end
            default: ;
          endcase
        end else begin
          case (cmd)
            C_RD_ARRAY: if (!active) stat_mode <= 1'b0;
            C_RD_STAT:  stat_mode <= 1'b1;
            C_CLR_STAT: begin
              seq_err <= 1'b0; vpp_err <= 1'b0; lock_err <= 1'b0;
            end
            C_ERASE, C_PROG, C_LOCK: begin
              stat_mode <= 1'b1;
              if (setup_ok)
                pend <= (cmd == C_ERASE) ? P_ERASE : (cmd == C_PROG) ? P_PROG : P_LOCK;
              else
                seq_err <= 1'b1;
            end
            C_SUSP: begin
              stat_mode <= 1'b1;
              if (susp_ok) spend <= SW'(SUSP_LAT);
            end
            C_GO: begin
              stat_mode <= 1'b1;
              if (psus) psus <= 1'b0;
              else if (esus && !run) begin
                esus <= 1'b0; run <= 1'b1; op <= O_ERASE; op_blk <= e_blk; cnt <= e_cnt;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORD; i++) mem[i] <= 16'hFFFF;
      lock_q <= '0;
    end else if (commit) begin
      case (op)
        O_ERASE: for (int w = 0; w < WPB; w++) mem[{op_blk, WORD_BITS'(w)}] <= 16'hFFFF;
        O_PROG:  mem[op_word] <= mem[op_word] & op_data;
        O_LSET:  lock_q[op_blk] <= 1'b1;
        O_LCLR:  lock_q[op_blk] <= 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout <= '0;
    else if (rd_en)
      dout <= stat_mode  ? {8'h00, status} :
              !byte_mode ? mem[widx] :
              {8'h00, addr[0] ? mem[widx][15:8] : mem[widx][7:0]};
  end

  // R3
  vpp_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lock_q) |-> $past(vpp_ok));

  // R4
  vcc_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !vcc_ok && hold_rst_n) |=> $stable(pend));

  // R5
  lock_respect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (op == O_ERASE || op == O_PROG)) |-> !lock_q[op_blk]);

  // R7
  susp_ack_chk: assert property (@(posedge clk) disable iff (!rst_n || !hold_rst_n)
    (active && spend == SW'(1)) |=> (esus || psus || !run));

  // R8
  esus_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && esus) |-> (op == O_PROG && op_blk != e_blk));

  // R9
  psus_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    psus |-> (run && !esus));
endmodule

// File: tb/test_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module test_flash_cmd_ctrl;
  localparam int BB = 5, WB = 3, EC = 40, PC = 12, LC = 8, SL = 2;
  localparam int AW = BB + WB + 1;
  localparam logic [7:0] K_RD = 8'hF0, K_ST = 8'h7A, K_CLR = 8'h5A, K_ER = 8'h2E, K_PG = 8'h4C;
  localparam logic [7:0] K_LK = 8'h6B, K_GO = 8'hC3, K_LSET = 8'h15, K_SUS = 8'hB5;

  logic clk = 1'b0, rst_n = 1'b0, hold_rst_n = 1'b1, vcc_ok = 1'b1, vpp_ok = 1'b1;
  logic byte_mode = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic busy;
  int checks = 0, fails = 0;
  logic [15:0] m_mem [256];
  logic [31:0] m_lock = '0;
  logic [15:0] q;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl #(.BLK_BITS(BB), .WORD_BITS(WB), .ERASE_CYC(EC), .PROG_CYC(PC),
                   .LOCK_CYC(LC), .SUSP_LAT(SL)) i_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .hold_rst_n(hold_rst_n), .vcc_ok(vcc_ok), .vpp_ok(vpp_ok),
    .byte_mode(byte_mode), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .din(din),
    .dout(dout), .busy(busy));

  function automatic logic [AW-1:0] ad(input int b, input int w);
    return {b[BB-1:0], w[WB-1:0], 1'b0};
  endfunction

  function automatic logic [15:0] st(input bit rdy, input bit es, input bit sq,
                                     input bit vp, input bit ps, input bit lk);
    return {8'h00, rdy, es, sq, 1'b0, vp, ps, lk, 1'b0};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; din = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [15:0] r);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; r = dout;
  endtask

  task automatic run_time(input int n, input string tag);
    repeat (n - 1) @(negedge clk);
    chk(tag, {15'd0, busy}, 16'd1);
    @(negedge clk);
    chk(tag, {15'd0, busy}, 16'd0);
  endtask

  task automatic prog_ok(input int b, input int w, input logic [15:0] d);
    wr(ad(b, w), {8'h00, K_PG});
    wr(ad(b, w), d);
    run_time(PC, "R6 program time");
    m_mem[b*8+w] = m_mem[b*8+w] & d;
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed_sink;
    seed_sink = $urandom(32'd4711);
    for (int i = 0; i < 256; i++) m_mem[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(ad(3, 5), q); chk("R13 reset array read", q, 16'hFFFF);
    wr(ad(0, 0), {8'h00, K_ST});
    rd(ad(0, 0), q); chk("R13 reset status", q, st(1,0,0,0,0,0));

    wr(ad(1, 2), {8'h00, K_PG});
    chk("R1 setup alone not busy", {15'd0, busy}, 16'd0);
    rd(ad(1, 2), q); chk("R1 setup alone status", q, st(1,0,0,0,0,0));
    wr(ad(1, 2), 16'h1234);
    run_time(PC, "R6 program time");
    m_mem[1*8+2] = 16'h1234;
    rd(ad(1, 2), q); chk("R11 status after completion", q, st(1,0,0,0,0,0));
    wr(ad(0, 0), {8'h00, K_RD});
    rd(ad(1, 2), q); chk("R6 programmed word", q, 16'h1234);

    wr(ad(1, 0), {8'h00, K_ER}); wr(ad(1, 0), 16'h0033);
    chk("R2 bad confirm not busy", {15'd0, busy}, 16'd0);
    rd(ad(1, 0), q); chk("R2 sequence error", q, st(1,0,1,0,0,0));
    wr(ad(0, 0), {8'h00, K_CLR});
    rd(ad(1, 0), q); chk("R14 cleared status", q, st(1,0,0,0,0,0));
    wr(ad(0, 0), {8'h00, K_RD});
    rd(ad(1, 2), q); chk("R2 array unchanged", q, 16'h1234);

    vpp_ok = 1'b0;
    wr(ad(1, 2), {8'h00, K_PG}); wr(ad(1, 2), 16'h0000);
    rd(ad(1, 2), q); chk("R3 voltage error", q, st(1,0,0,1,0,0));
    wr(ad(1, 0), {8'h00, K_LK}); wr(ad(1, 0), {8'h00, K_LSET});
    chk("R3 lock not started", {15'd0, busy}, 16'd0);
    vpp_ok = 1'b1;
    wr(ad(0, 0), {8'h00, K_CLR}); wr(ad(0, 0), {8'h00, K_RD});
    rd(ad(1, 2), q); chk("R3 array unchanged", q, 16'h1234);
    prog_ok(1, 3, 16'h00FF);
    wr(ad(0, 0), {8'h00, K_RD});
    rd(ad(1, 3), q); chk("R3 block left unlocked", q, 16'h00FF);

    vcc_ok = 1'b0;
    wr(ad(0, 0), {8'h00, K_ST});
    wr(ad(0, 1), {8'h00, K_PG}); wr(ad(0, 1), 16'h0000);
    chk("R4 vcc low not busy", {15'd0, busy}, 16'd0);
    vcc_ok = 1'b1;
    rd(ad(0, 1), q); chk("R4 vcc low writes ignored", q, 16'hFFFF);

    prog_ok(2, 0, 16'hAAAA);
    wr(ad(2, 0), {8'h00, K_ER}); wr(ad(2, 0), {8'h00, K_GO});
    repeat (5) @(negedge clk);
    hold_rst_n = 1'b0;
    wr(ad(0, 0), {8'h00, K_ST});
    hold_rst_n = 1'b1;
    chk("R4 hold aborts", {15'd0, busy}, 16'd0);
    rd(ad(2, 0), q); chk("R4 hold array mode and data kept", q, 16'hAAAA);

    wr(ad(3, 0), {8'h00, K_LK}); wr(ad(3, 0), {8'h00, K_LSET});
    run_time(LC, "R6 lock time");
    m_lock[3] = 1'b1;
    wr(ad(3, 1), {8'h00, K_PG}); wr(ad(3, 1), 16'h0000);
    rd(ad(3, 1), q); chk("R5 program locked", q, st(1,0,0,0,0,1));
    wr(ad(0, 0), {8'h00, K_CLR});
    wr(ad(3, 1), {8'h00, K_ER}); wr(ad(3, 1), {8'h00, K_GO});
    rd(ad(3, 1), q); chk("R5 erase locked", q, st(1,0,0,0,0,1));
    wr(ad(0, 0), {8'h00, K_CLR}); wr(ad(0, 0), {8'h00, K_RD});
    rd(ad(3, 1), q); chk("R5 array unchanged", q, 16'hFFFF);
    wr(ad(3, 0), {8'h00, K_LK}); wr(ad(3, 0), {8'h00, K_GO});
    run_time(LC, "R6 unlock time");
    m_lock[3] = 1'b0;
    prog_ok(3, 1, 16'h0F00);

    prog_ok(4, 0, 16'h00F0);
    wr(ad(4, 0), {8'h00, K_ER}); wr(ad(4, 0), {8'h00, K_GO});
    repeat (9) @(negedge clk);
    wr(ad(0, 0), {8'h00, K_SUS});
    repeat (SL - 1) @(negedge clk);
    chk("R7 erase suspend not early", {15'd0, busy}, 16'd1);
    @(negedge clk);
    chk("R7 erase suspend ack", {15'd0, busy}, 16'd0);
    rd(ad(0, 0), q); chk("R7 erase suspend status", q, st(1,1,0,0,0,0));
    wr(ad(0, 0), {8'h00, K_RD});
    rd(ad(4, 0), q); chk("R8 read during erase suspend", q, 16'h00F0);
    prog_ok(5, 1, 16'h5555);
    rd(ad(0, 0), q); chk("R8 program in erase suspend", q, st(1,1,0,0,0,0));
    wr(ad(4, 2), {8'h00, K_PG}); wr(ad(4, 2), 16'h0000);
    rd(ad(0, 0), q); chk("R8 program to erasing block", q, st(1,1,1,0,0,0));
    wr(ad(0, 0), {8'h00, K_CLR});
    wr(ad(0, 0), {8'h00, K_GO});
    run_time(EC - 9 - SL - 1, "R10 erase resume time");
    for (int w = 0; w < 8; w++) m_mem[4*8+w] = 16'hFFFF;
    wr(ad(0, 0), {8'h00, K_RD});
    rd(ad(4, 0), q); chk("R10 erase completed", q, 16'hFFFF);
    rd(ad(5, 1), q); chk("R8 other block programmed", q, 16'h5555);

    wr(ad(6, 2), {8'h00, K_PG}); wr(ad(6, 2), 16'h0F0F);
    repeat (3) @(negedge clk);
    wr(ad(0, 0), {8'h00, K_SUS});
    repeat (SL - 1) @(negedge clk);
    chk("R7 program suspend not early", {15'd0, busy}, 16'd1);
    @(negedge clk);
    chk("R7 program suspend ack", {15'd0, busy}, 16'd0);
    rd(ad(0, 0), q); chk("R7 program suspend status", q, st(1,0,0,0,1,0));
    wr(ad(0, 0), {8'h00, K_ER});
    rd(ad(0, 0), q); chk("R9 erase refused", q, st(1,0,1,0,1,0));
    wr(ad(0, 0), {8'h00, K_CLR});
    wr(ad(7, 0), {8'h00, K_PG});
    rd(ad(0, 0), q); chk("R9 program refused", q, st(1,0,1,0,1,0));
    wr(ad(0, 0), {8'h00, K_CLR}); wr(ad(0, 0), {8'h00, K_RD});
    rd(ad(6, 2), q); chk("R9 read during program suspend", q, 16'hFFFF);
    wr(ad(0, 0), {8'h00, K_GO});
    run_time(PC - 3 - SL - 1, "R10 program resume time");
    m_mem[6*8+2] = 16'h0F0F;
    wr(ad(0, 0), {8'h00, K_RD});
    rd(ad(6, 2), q); chk("R10 program completed", q, 16'h0F0F);

    wr(ad(7, 0), {8'h00, K_ER}); wr(ad(7, 0), {8'h00, K_GO});
    wr(ad(0, 0), {8'h00, K_RD});
    rd(ad(7, 0), q); chk("R11 read array ignored when busy", q, st(0,0,0,0,0,0));
    wait (busy == 1'b0);

    byte_mode = 1'b1;
    wr({ad(7, 3)} | 9'd1, {8'h00, K_PG}); wr(ad(7, 3) | 9'd1, 16'h003C);
    run_time(PC, "R6 byte program time");
    m_mem[7*8+3] = 16'h3CFF;
    wr(ad(0, 0), {8'h00, K_RD});
    rd(ad(7, 3) | 9'd1, q); chk("R12 byte high lane", q, 16'h003C);
    rd(ad(7, 3), q); chk("R12 byte low lane", q, 16'h00FF);
    byte_mode = 1'b0;
    rd(ad(7, 3), q); chk("R12 word view", q, 16'h3CFF);

    for (int it = 0; it < 40; it++) begin
      int kind, b, w;
      logic [15:0] d, e;
      logic v;
      kind = $urandom_range(0, 4); b = $urandom_range(0, 7); w = $urandom_range(0, 7);
      d = 16'($urandom); v = ($urandom_range(0, 7) != 0);
      vpp_ok = v;
      e = st(1,0,0,0,0,0);
      case (kind)
        0: begin
          wr(ad(b, w), {8'h00, K_PG}); wr(ad(b, w), d);
          if (m_lock[b]) e = st(1,0,0,0,0,1);
          else if (!v) e = st(1,0,0,1,0,0);
          else begin run_time(PC, "R6 random program"); m_mem[b*8+w] = m_mem[b*8+w] & d; end
        end
        1: begin
          wr(ad(b, w), {8'h00, K_ER}); wr(ad(b, w), {8'h00, K_GO});
          if (m_lock[b]) e = st(1,0,0,0,0,1);
          else if (!v) e = st(1,0,0,1,0,0);
          else begin
            run_time(EC, "R6 random erase");
            for (int k = 0; k < 8; k++) m_mem[b*8+k] = 16'hFFFF;
          end
        end
        2, 3: begin
          wr(ad(b, w), {8'h00, K_LK}); wr(ad(b, w), {8'h00, (kind == 2) ? K_LSET : K_GO});
          if (!v) e = st(1,0,0,1,0,0);
          else begin run_time(LC, "R5 random lock"); m_lock[b] = (kind == 2); end
        end
        default: begin
          wr(ad(b, w), {8'h00, K_LK}); wr(ad(b, w), 16'h0077);
          e = st(1,0,1,0,0,0);
        end
      endcase
      rd(ad(0, 0), q); chk("R11 random status", q, e);
      vpp_ok = 1'b1;
      wr(ad(0, 0), {8'h00, K_CLR}); wr(ad(0, 0), {8'h00, K_RD});
      b = $urandom_range(0, 7); w = $urandom_range(0, 7);
      rd(ad(b, w), q); chk("R6 random array", q, m_mem[b*8+w]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule